// File: doc/BRIEF.md
# Low-Transition Swapped-Output Pattern Generator

This block produces a new pseudo-random test pattern on each enabled clock for built-in self-test. Inside it sits a plain Fibonacci shift register with linear feedback. The parallel output is not the register state itself. It first passes through a row of 2:1 multiplexers, and these can exchange the values of neighbouring bits.

All of those multiplexers share a single select, taken from the most significant register bit. When that bit is 0, the pattern equals the state. When it is 1, every lower pair of bits is exchanged. On average this removes about a quarter of the bit flips between consecutive patterns, compared with reading the raw register. A seed can be loaded at any time. A seed of zero would lock the register, so it is replaced by a nonzero default.

Top module: `swap_lfsr_gen`

## Requirements
- R1: While reset is asserted and on leaving it, the register holds DEFAULT_SEED (default 1). With the default, the pattern equals 36'h000000001.
- R2: A load request with a nonzero seed makes the register hold that seed on the following clock edge.
- R3: A load request with an all-zero seed loads DEFAULT_SEED instead of zero.
- R4: When load and enable are both high in the same cycle, the load wins and no shift happens.
- R5: With load and enable both low, the register and the pattern keep their values.
- R6: Each enabled step shifts the register one place toward the MSB. Bit 0 receives the XOR of the register bits selected by TAP_MASK (default: bits 35 and 24).
- R7: When register bit WIDTH-1 is 0, the pattern equals the register bit for bit.
- R8: When register bit WIDTH-1 is 1, pattern bits 2k and 2k+1 are the register bits 2k+1 and 2k, for k = 0 .. (WIDTH-1)/2-1. The remaining upper bits (34 and 35 at the default width) pass unchanged.
- R9: Starting from any legal load, the register never becomes all zero.
- R10: Over a long run of steps, the summed pattern-to-pattern bit flips on the output are fewer than the flips in the raw register for the same seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the register by one step |
| seedLoad | input | 1 | Load seedValue (zero is replaced by the default) |
| seedValue | input | WIDTH | Seed to load |
| pattern | output | WIDTH | Swapped test pattern |

## Verification
The hardest case to reach is the swapped view together with its effect on transition counts. The select bit is the register MSB, and from the ports it can only be seen indirectly. The bench loads seeds with the MSB set and seeds with it clear, and it loads a zero seed. It then runs several thousand steps with pauses scattered through them, so the select toggles often. While doing so it counts output flips against the flips of a behavioural model of the plain register started from the same seed.

// File: rtl/swap_lfsr_pkg.sv
package swap_lfsr_pkg;

  // Per-cycle commands from control to the datapath
  typedef struct packed {
    logic loadSeed;     // take the external seed
    logic loadDefault;  // take the built-in nonzero seed
    logic advance;      // one shift step
  } genStrobes_t;

endpackage

// File: rtl/swap_lfsr_ctrl.sv
module swap_lfsr_ctrl
  import swap_lfsr_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedValue,
  output genStrobes_t      strobes
);

  logic seedIsZero;

  always_comb begin
    seedIsZero          = (seedValue == '0);
    strobes.loadSeed    = seedLoad && !seedIsZero;
    strobes.loadDefault = seedLoad && seedIsZero;
    // a load always takes priority over stepping
    strobes.advance     = enable && !seedLoad;
  end

endmodule

// File: rtl/swap_lfsr_swapnet.sv
module swap_lfsr_swapnet #(
  parameter int WIDTH = 36
) (
  input  logic             swapSel,
  input  logic [WIDTH-1:0] rawBits,
  output logic [WIDTH-1:0] outBits
);

  localparam int NUM_PAIRS   = (WIDTH - 1) / 2;
  localparam int PAIRED_BITS = 2 * NUM_PAIRS;

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign outBits[2*p]   = swapSel ? rawBits[2*p+1] : rawBits[2*p];
      assign outBits[2*p+1] = swapSel ? rawBits[2*p]   : rawBits[2*p+1];
    end
    for (p = PAIRED_BITS; p < WIDTH; p++) begin : g_pass
      assign outBits[p] = rawBits[p];
    end
  endgenerate

endmodule

// File: rtl/swap_lfsr_core.sv
module swap_lfsr_core
  import swap_lfsr_pkg::*;
#(
  parameter int               WIDTH        = 36,
  parameter logic [WIDTH-1:0] TAP_MASK     = 36'h801000000,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 36'h000000001
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobes_t      strobes,
  input  logic [WIDTH-1:0] seedValue,
  output logic [WIDTH-1:0] pattern
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stateQ;
  logic             feedback;

  assign feedback = ^(stateQ & TAP_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= DEFAULT_SEED;
    end else if (strobes.loadDefault) begin
      stateQ <= DEFAULT_SEED;
    end else if (strobes.loadSeed) begin
      stateQ <= seedValue;
    end else if (strobes.advance) begin
      stateQ <= {stateQ[MSB-1:0], feedback};
    end
  end

  swap_lfsr_swapnet #(.WIDTH(WIDTH)) swapNet (
    .swapSel (stateQ[MSB]),
    .rawBits (stateQ),
    .outBits (pattern)
  );

  // R2
  seed_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSeed |=> stateQ == $past(seedValue));

  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDefault |=> stateQ == DEFAULT_SEED);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadSeed && !strobes.loadDefault && !strobes.advance) |=> $stable(stateQ));

  // R6
  shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> stateQ[MSB:1] == $past(stateQ[MSB-1:0]));

  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != '0);

  // R7
  pass_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pattern[MSB] |-> $countones(pattern) == $countones(stateQ));

endmodule

// File: rtl/swap_lfsr_gen.sv
module swap_lfsr_gen
  import swap_lfsr_pkg::*;
#(
  parameter int               WIDTH        = 36,
  parameter logic [WIDTH-1:0] TAP_MASK     = 36'h801000000,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 36'h000000001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedValue,
  output logic [WIDTH-1:0] pattern
);

  genStrobes_t strobes;

  swap_lfsr_ctrl #(.WIDTH(WIDTH)) ctrl (
    .enable    (enable),
    .seedLoad  (seedLoad),
    .seedValue (seedValue),
    .strobes   (strobes)
  );

  swap_lfsr_core #(
    .WIDTH        (WIDTH),
    .TAP_MASK     (TAP_MASK),
    .DEFAULT_SEED (DEFAULT_SEED)
  ) core (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .seedValue (seedValue),
    .pattern   (pattern)
  );

  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && enable && seedValue != '0) |=> pattern[WIDTH-1] == $past(seedValue[WIDTH-1]));

endmodule

// File: tb/swap_lfsr_gen_test.sv
`timescale 1ns/1ps
module swap_lfsr_gen_test;

  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         seedLoad = 1'b0;
  logic [W-1:0] seedValue = '0;
  logic [W-1:0] pattern;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] modelState = 36'h1;
  logic [W-1:0] prevPat;
  logic [W-1:0] prevRaw;
  bit           countOn = 0;
  longint       swapFlips = 0;
  longint       rawFlips = 0;

  always #5 clk = ~clk;

  swap_lfsr_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .seedLoad(seedLoad), .seedValue(seedValue), .pattern(pattern)
  );

  function automatic logic [W-1:0] viewOf(input logic [W-1:0] s);
    logic [W-1:0] v;
    v = s;
    if (s[W-1]) begin
      for (int k = 0; k + 1 < W - 1; k += 2) begin
        v[k]   = s[k+1];
        v[k+1] = s[k];
      end
    end
    return v;
  endfunction

  function automatic logic [W-1:0] stepOf(input logic [W-1:0] s);
    int ones;
    ones = 0;
    if (s[35]) ones++;
    if (s[24]) ones++;
    return {s[W-2:0], ones[0]};
  endfunction

  function automatic int flipsOf(input logic [W-1:0] a, input logic [W-1:0] b);
    int n;
    n = 0;
    for (int i = 0; i < W; i++) if (a[i] != b[i]) n++;
    return n;
  endfunction

  task automatic checkNow(input string tag);
    logic [W-1:0] exp;
    exp = viewOf(modelState);
    total++;
    if (pattern !== exp) begin
      bad++;
      $display("FAIL %s pattern=%h expected=%h", tag, pattern, exp);
    end
    if (countOn) begin
      swapFlips += flipsOf(pattern, prevPat);
      rawFlips  += flipsOf(modelState, prevRaw);
    end
    prevPat = pattern;
    prevRaw = modelState;
  endtask

  // compare at negedge, then drive this cycle's inputs and advance the model
  task automatic cycle(input string tag, input logic en, input logic ld, input logic [W-1:0] sd);
    @(negedge clk);
    checkNow(tag);
    enable = en; seedLoad = ld; seedValue = sd;
    if (ld) modelState = (sd == '0) ? 36'h1 : sd;
    else if (en) modelState = stepOf(modelState);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      checkNow("R1");
    end
    rstN = 1'b1;
    cycle("R1", 1'b0, 1'b0, '0);
    cycle("R5", 1'b0, 1'b0, '0);
    // R2 load with MSB set, then R8 swapped view
    cycle("R5", 1'b0, 1'b1, 36'h9_A5C3_1E07);
    cycle("R8", 1'b0, 1'b0, '0);
    cycle("R8", 1'b0, 1'b1, 36'h4_F00F_5AA5);
    // R7 pass-through view
    cycle("R7", 1'b0, 1'b0, '0);
    // R3 zero seed
    cycle("R2", 1'b0, 1'b1, '0);
    cycle("R3", 1'b0, 1'b0, '0);
    // R4 load while enabled
    cycle("R3", 1'b1, 1'b1, 36'hF_0000_0003);
    cycle("R4", 1'b0, 1'b0, '0);
    // R6 stepping, R5 pauses, R10 flip counting
    countOn = 1;
    for (int n = 0; n < 4000; n++) begin
      if (n % 11 == 5) cycle("R5", 1'b0, 1'b0, '0);
      else cycle("R6", 1'b1, 1'b0, '0);
    end
    cycle("R9", 1'b0, 1'b0, '0);
    // R10 fewer flips on the swapped output than on the raw register
    total++;
    if (!(swapFlips < rawFlips)) begin
      bad++;
      $display("FAIL R10 swapped flips=%0d expected below raw flips=%0d", swapFlips, rawFlips);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule